// File: doc/BRIEF.md
# Slot-1 Branch Next-Fetch-Address Unit

This unit produces the fetch address for a wide-issue pipeline whose instruction words (bundles) hold a fixed number of operation slots. It holds the fetch address register. In the cycle a bundle sits in decode, it reads that bundle's branch decode fields and the integer register operand read there, and picks the address fetched on the following cycle. Only the first issue slot may carry a branch. Two conditional branch forms exist: branch when the register is zero and branch when the register is non-zero.

A branch is resolved in decode. In that cycle the fetch stage is already reading the bundle that sequentially follows the branch, and that bundle is never cancelled. It forms a single delay slot that executes whether the branch is taken or not. The redirect affects only the fetch after it. The target is the delay-slot address plus a sign-extended offset counted in whole bundles. A branch flag in any other slot is reported on an illegal-branch output and otherwise treated as a no-op. A stall input freezes the fetch address.

Top module: `slot1_branch_nextpc`

## Requirements
- R1: While `rst_n` is low, `fetch_pc` equals the parameter `RESET_PC` (default 0x1000).
- R2: On a clock edge with `stall` low and no taken branch, `fetch_pc` advances by one bundle (`NSLOT*OP_BYTES`, 20 bytes by default), wrapping modulo 2^AW.
- R3: `br_taken` is high exactly when `dec_valid` is high, `stall` is low, `dec_br_slot[0]` (slot 1) is set, and the condition holds. The condition is `dec_rs_val != 0` when `dec_br_ne` is 1, and `dec_rs_val == 0` when `dec_br_ne` is 0.
- R4: After an edge at which `br_taken` was high, `fetch_pc` equals the `fetch_pc` of the decode cycle plus the sign-extended `dec_offset` times the bundle size, modulo 2^AW.
- R5: In the cycle a branch is decoded, `fetch_pc` is the sequential successor of the branch bundle (the delay slot). This holds whether the branch is taken or not. The redirect applies only to the next fetch, so the delay slot is never replaced.
- R6: `illegal_br` is high while `dec_valid` is high and any of `dec_br_slot[NSLOT-1:1]` is set. Such flags have no effect on `br_taken` or on the next `fetch_pc`.
- R7: While `stall` is high, `fetch_pc` holds its value across the edge and `br_taken` is low.
- R8: While `dec_valid` is low, all decode fields are ignored: `br_taken` and `illegal_br` are low and the fetch address advances sequentially.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freeze fetch address and suppress branch |
| dec_valid | input | 1 | Decode stage holds a valid bundle |
| dec_br_slot | input | NSLOT (5) | Per-slot branch-opcode flag; bit 0 is slot 1 |
| dec_br_ne | input | 1 | Slot-1 branch kind: 1 = branch if non-zero, 0 = branch if zero |
| dec_offset | input | OFFW (16) | Signed branch offset in bundles |
| dec_rs_val | input | XLEN (32) | Register operand read in decode |
| fetch_pc | output | AW (32) | Current fetch byte address |
| br_taken | output | 1 | Slot-1 branch is taken this cycle |
| illegal_br | output | 1 | Branch opcode found outside slot 1 |

## Verification
Embedded assertions check on every cycle that a stall freezes the address and blocks a taken branch. They also check that untaken cycles step by exactly one bundle, that a taken branch lands on the delay-slot address plus the scaled offset, and that an invalid decode never branches or flags. What only the bench scenarios can show is the full timing relation across a branch. The bench sweeps every slot-flag pattern, both branch kinds, zero, sign-bit and all-ones operands, and positive and negative offsets. For each case it shows that the delay-slot address is presented in the decode cycle and that the redirect follows one cycle later, computing every address arithmetically.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

   typedef enum logic {
      COND_IF_ZERO    = 1'b0,
      COND_IF_NONZERO = 1'b1
   } br_cond_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int log2_floor(input int v);
      int r;
      r = 0;
      while ((1 << (r + 1)) <= v) r++;
      return r;
   endfunction

endpackage

// File: rtl/br_zero_detect.sv
module br_zero_detect #(
   parameter int XLEN  = 32,
   parameter int CHUNK = 8
) (
   input  logic [XLEN-1:0] value,
   output logic            is_nonzero
);
   localparam int NCHUNK = (XLEN + CHUNK - 1) / CHUNK;
   localparam int PADW   = NCHUNK * CHUNK;

   if (XLEN < 1)  begin : g_bad_xlen  $error("XLEN must be positive");  end
   if (CHUNK < 1) begin : g_bad_chunk $error("CHUNK must be positive"); end

   if (XLEN <= CHUNK) begin : g_flat
      assign is_nonzero = |value;
   end else begin : g_tree
      logic [PADW-1:0]   padded;
      logic [NCHUNK-1:0] part;
      assign padded = PADW'(value);
      for (genvar c = 0; c < NCHUNK; c++) begin : g_part
         assign part[c] = |padded[c*CHUNK +: CHUNK];
      end
      assign is_nonzero = |part;
   end
endmodule

// File: rtl/br_slot_check.sv
module br_slot_check #(
   parameter int NSLOT = 5
) (
   input  logic             dec_valid,
   input  logic [NSLOT-1:0] dec_br_slot,
   output logic             slot1_branch,
   output logic             misplaced
);
   if (NSLOT < 1) begin : g_bad_nslot $error("NSLOT must be at least 1"); end

   assign slot1_branch = dec_valid & dec_br_slot[0];

   if (NSLOT > 1) begin : g_multi
      assign misplaced = dec_valid & (|dec_br_slot[NSLOT-1:1]);
   end else begin : g_single
      assign misplaced = 1'b0;
   end
endmodule

// File: rtl/br_target_gen.sv
module br_target_gen #(
   parameter int AW           = 32,
   parameter int OFFW         = 16,
   parameter int BUNDLE_BYTES = 20
) (
   input  logic [AW-1:0]   base_pc,
   input  logic [OFFW-1:0] offset,
   output logic [AW-1:0]   target
);
   import nextpc_pkg::*;

   if (OFFW > AW)         begin : g_bad_offw $error("OFFW must not exceed AW"); end
   if (BUNDLE_BYTES < 1)  begin : g_bad_bb   $error("BUNDLE_BYTES must be positive"); end

   logic signed [AW-1:0] off_ext;
   logic        [AW-1:0] scaled;

   assign off_ext = AW'($signed(offset));

   if (is_pow2(BUNDLE_BYTES)) begin : g_shift
      localparam int SH = log2_floor(BUNDLE_BYTES);
      assign scaled = AW'(off_ext <<< SH);
   end else begin : g_mult
      localparam logic [AW-1:0] SCALE = AW'(BUNDLE_BYTES);
      assign scaled = AW'(off_ext * $signed(SCALE));
   end

   assign target = base_pc + scaled;
endmodule

// File: rtl/slot1_branch_nextpc.sv
module slot1_branch_nextpc #(
   parameter int              AW       = 32,
   parameter int              NSLOT    = 5,
   parameter int              OP_BYTES = 4,
   parameter int              OFFW     = 16,
   parameter int              XLEN     = 32,
   parameter logic [AW-1:0]   RESET_PC = 32'h0000_1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stall,
   input  logic             dec_valid,
   input  logic [NSLOT-1:0] dec_br_slot,
   input  logic             dec_br_ne,
   input  logic [OFFW-1:0]  dec_offset,
   input  logic [XLEN-1:0]  dec_rs_val,
   output logic [AW-1:0]    fetch_pc,
   output logic             br_taken,
   output logic             illegal_br
);
   import nextpc_pkg::*;

   localparam int            BUNDLE_BYTES = NSLOT * OP_BYTES;
   localparam logic [AW-1:0] STEP         = AW'(BUNDLE_BYTES);

   if (AW < 2)       begin : g_bad_aw  $error("AW too small"); end
   if (OP_BYTES < 1) begin : g_bad_op  $error("OP_BYTES must be positive"); end

   logic          slot1_br;
   logic          rs_nonzero;
   logic          cond_ok;
   logic [AW-1:0] target_pc;
   logic [AW-1:0] seq_pc;
   logic [AW-1:0] next_pc;
   br_cond_e      cond_kind;

   br_slot_check #(.NSLOT(NSLOT)) u_slots (
      .dec_valid    (dec_valid),
      .dec_br_slot  (dec_br_slot),
      .slot1_branch (slot1_br),
      .misplaced    (illegal_br)
   );

   br_zero_detect #(.XLEN(XLEN), .CHUNK(8)) u_zero (
      .value      (dec_rs_val),
      .is_nonzero (rs_nonzero)
   );

   br_target_gen #(.AW(AW), .OFFW(OFFW), .BUNDLE_BYTES(BUNDLE_BYTES)) u_target (
      .base_pc (fetch_pc),
      .offset  (dec_offset),
      .target  (target_pc)
   );

   assign cond_kind = br_cond_e'(dec_br_ne);

   always_comb begin
      unique case (cond_kind)
         COND_IF_NONZERO: cond_ok = rs_nonzero;
         default:         cond_ok = ~rs_nonzero;
      endcase
   end

   assign br_taken = slot1_br & cond_ok & ~stall;
   assign seq_pc   = fetch_pc + STEP;
   assign next_pc  = br_taken ? target_pc : seq_pc;

   always_ff @(posedge clk) begin
      if (!rst_n)      fetch_pc <= RESET_PC;
      else if (!stall) fetch_pc <= next_pc;
   end

   // R7: a stalled cycle keeps the address and never branches
   a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(fetch_pc));
   a_r7_stall_no_branch: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> !br_taken);

   // R2: untaken, unstalled cycles advance by exactly one bundle
   a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && !br_taken) |=> fetch_pc == AW'($past(fetch_pc) + STEP));

   // R4: taken branch lands on delay-slot address plus scaled offset
   a_r4_target: assert property (@(posedge clk) disable iff (!rst_n)
      br_taken |=> fetch_pc == AW'($past(fetch_pc)
                      + AW'($signed($past(dec_offset)) * BUNDLE_BYTES)));

   // R3: a taken branch needs a valid slot-1 branch opcode
   a_r3_taken_needs_slot1: assert property (@(posedge clk) disable iff (!rst_n)
      br_taken |-> (dec_valid && dec_br_slot[0]));

   // R6: misplaced branch flags alone never redirect fetch
   a_r6_misplaced_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (illegal_br && !dec_br_slot[0] && !stall) |=> fetch_pc == AW'($past(fetch_pc) + STEP));

   // R8: an empty decode stage produces no branch and no flag
   a_r8_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> (!br_taken && !illegal_br));

   // R1: reset loads the reset address
   a_r1_reset_value: assert property (@(posedge clk)
      !rst_n |=> fetch_pc == RESET_PC);
endmodule

// File: tb/slot1_branch_nextpc_bench.sv
module slot1_branch_nextpc_bench;
   localparam int          CLK_PERIOD = 10;
   localparam int          AW         = 32;
   localparam int          NSLOT      = 5;
   localparam int          OFFW       = 16;
   localparam int          XLEN       = 32;
   localparam logic [31:0] RST_ADDR   = 32'h0000_1000;
   localparam logic [31:0] BUNDLE     = 32'd20;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             stall;
   logic             dec_valid;
   logic [NSLOT-1:0] dec_br_slot;
   logic             dec_br_ne;
   logic [OFFW-1:0]  dec_offset;
   logic [XLEN-1:0]  dec_rs_val;
   logic [AW-1:0]    fetch_pc;
   logic             br_taken;
   logic             illegal_br;

   int          checks = 0;
   int          errors = 0;
   logic [31:0] exp_pc;
   int          case_no = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   slot1_branch_nextpc u_slot1_branch_nextpc (
      .clk(clk), .rst_n(rst_n), .stall(stall), .dec_valid(dec_valid),
      .dec_br_slot(dec_br_slot), .dec_br_ne(dec_br_ne), .dec_offset(dec_offset),
      .dec_rs_val(dec_rs_val), .fetch_pc(fetch_pc), .br_taken(br_taken),
      .illegal_br(illegal_br)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (case %0d)", req, act, expv, case_no);
      end
   endtask

   // One decode cycle: drive at negedge, check combinational outputs and the
   // presented address, then check the address after the edge.
   task automatic step(input logic v, input logic [4:0] m, input logic ne,
                       input logic [15:0] off, input logic [31:0] rs,
                       input logic st, input string pre_req);
      logic        e_taken;
      logic        e_ill;
      logic [31:0] soff;
      logic [31:0] nxt;
      string       post_req;
      dec_valid = v; dec_br_slot = m; dec_br_ne = ne;
      dec_offset = off; dec_rs_val = rs; stall = st;
      #1;
      e_taken = v && !st && m[0] && (ne ? (rs != 0) : (rs == 0));
      e_ill   = v && (m[4:1] != 4'b0);
      chk(br_taken == e_taken, v ? (st ? "R7" : "R3") : "R8", 32'(br_taken), 32'(e_taken));
      chk(illegal_br == e_ill, v ? "R6" : "R8", 32'(illegal_br), 32'(e_ill));
      chk(fetch_pc == exp_pc, pre_req, fetch_pc, exp_pc);
      soff = {{16{off[15]}}, off};
      if (st)           begin nxt = exp_pc;                post_req = "R7"; end
      else if (e_taken) begin nxt = exp_pc + soff * BUNDLE; post_req = "R4"; end
      else              begin nxt = exp_pc + BUNDLE;       post_req = v ? ((m[4:1] != 0) ? "R6" : "R2") : "R8"; end
      @(posedge clk);
      @(negedge clk);
      exp_pc = nxt;
      chk(fetch_pc == exp_pc, post_req, fetch_pc, exp_pc);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] rs_set [4];
      logic [15:0] off_set [5];
      rs_set[0] = 32'h0;  rs_set[1] = 32'h1;  rs_set[2] = 32'h8000_0000; rs_set[3] = 32'hFFFF_FFFF;
      off_set[0] = 16'd0; off_set[1] = 16'd1; off_set[2] = 16'hFFFF;
      off_set[3] = 16'hFFFD; off_set[4] = 16'd7;
      rst_n = 1'b0; stall = 1'b0; dec_valid = 1'b0; dec_br_slot = '0;
      dec_br_ne = 1'b0; dec_offset = '0; dec_rs_val = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(fetch_pc == RST_ADDR, "R1", fetch_pc, RST_ADDR);
      chk(br_taken == 1'b0, "R1", 32'(br_taken), 32'd0);
      rst_n = 1'b1;
      exp_pc = RST_ADDR;
      step(1'b0, 5'b0, 1'b0, 16'd0, 32'd0, 1'b0, "R1");
      for (int m = 0; m < 32; m++) begin
         for (int ne = 0; ne < 2; ne++) begin
            for (int ri = 0; ri < 4; ri++) begin
               for (int oi = 0; oi < 5; oi++) begin
                  case_no++;
                  step(1'b1, 5'b0, 1'b0, 16'd0, 32'd0, 1'b0, "R2");
                  if ((case_no % 4) == 0)
                     step(1'b1, 5'(m), 1'(ne), off_set[oi], rs_set[ri], 1'b1, "R7");
                  // R5: delay-slot address presented during the branch's decode
                  step(1'b1, 5'(m), 1'(ne), off_set[oi], rs_set[ri], 1'b0, "R5");
                  // R5: the delay slot itself decodes without being cancelled
                  step(1'b1, 5'b0, 1'b0, 16'd0, 32'd0, 1'b0, "R5");
                  if ((case_no % 3) == 0)
                     step(1'b0, 5'(m), 1'(ne), off_set[oi], rs_set[ri], 1'b0, "R8");
               end
            end
         end
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule